// File: doc/BRIEF.md
# Three-Input Bitwise Truth-Table Unit

This unit evaluates an arbitrary Boolean function of three inputs on every bit position of 64-bit operands. An 8-bit truth table selects which of the 256 possible functions is applied. Each result bit is found by forming a 3-bit index from the three input bits and reading that entry of the table. Common uses include XOR of three values, majority, bitwise select, or any custom mix, all done with one operation.

A second, packed mode works on one 8-bit or 16-bit lane at a time. Three lane indices choose which lane of the first operand feeds each of the three function inputs. A fourth index chooses which lane of the old destination value is replaced. In this mode the truth table comes from the low byte of the second operand. All destination bits outside the written lane keep the old value.

The result is registered one cycle after a valid request. When recording is enabled, a one-hot sign/zero flag vector goes with it.

Top module: `lut3_unit`

## Requirements
- R1: After reset, `out_valid`, `result` and `flags` are all zero.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high and low otherwise, so the result has one cycle of latency.
- R3: With `mode_packed`=0, result bit i is `table_imm[{op_d[i], op_a[i], op_b[i]}]`. The index is formed as c*4 + b*2 + a, with a=`op_b`, b=`op_a` and c=`op_d`, and bit 0 of the table is entry 0.
- R4: In full-width mode, table 0x96 gives `op_a ^ op_b ^ op_d`, 0xE8 gives the bitwise majority of the three, and 0xCA gives `op_d ? op_a : op_b` per bit.
- R5: With `mode_packed`=1, the lane width is 8 bits when `wide_chunk`=0 and 16 bits when `wide_chunk`=1.
- R6: In packed mode, lane bit j uses a=`op_a[off_a+j]`, b=`op_a[off_b+j]` and c=`op_a[off_c+j]`, where off_x = min(idx_x × width, 64). The table is `op_b[7:0]`, and `table_imm` has no effect.
- R7: In packed mode, bits off_d..off_d+width-1 of `result` take the lane outputs. Every other bit equals `op_d`.
- R8: A source bit position of 64 or above reads as zero. A destination position of 64 or above is not written, so a clamped destination offset leaves `result` equal to `op_d`.
- R9: With `rec_en`=1, `flags` = {negative, positive, zero} of the signed 64-bit result, and exactly one bit is set. With `rec_en`=0, `flags` is 000.
- R10: While `in_valid` is low, `result` and `flags` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| mode_packed | input | 1 | 0 full-width, 1 packed lane |
| wide_chunk | input | 1 | Packed lane width: 0 = 8 bits, 1 = 16 bits |
| rec_en | input | 1 | Produce sign/zero flags |
| table_imm | input | 8 | Truth table for full-width mode |
| op_a | input | 64 | First operand (sole lane source in packed mode) |
| op_b | input | 64 | Second operand; low byte is the packed-mode table |
| op_d | input | 64 | Old destination value |
| idx_a | input | 4 | Packed lane index for input a |
| idx_b | input | 4 | Packed lane index for input b |
| idx_c | input | 4 | Packed lane index for input c |
| idx_d | input | 4 | Packed lane index for the written lane |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Registered result |
| flags | output | 3 | {negative, positive, zero} or 000 |

## Verification
Full-width mode is tried with pseudo-random operands under several tables. Single-input tables such as 0xAA and 0xF0 show whether the three inputs reach the right index bits. The named tables 0x96, 0xE8 and 0xCA tell symmetric functions apart from the asymmetric select, which exposes swapped operand roles.

Packed mode is run at both lane widths with distinct source indices, so a wrong lane or width shows up in a different lane value. Indices that clamp to 64 separate zero-fill on read from a suppressed write. Positive, negative and zero results, together with held cycles, cover the flags and the hold behaviour.

// File: rtl/lut3_pkg.sv
package lut3_pkg;

    typedef enum logic {
        OPM_FULL   = 1'b0,
        OPM_PACKED = 1'b1
    } op_mode_e;

    typedef struct packed {
        logic neg;
        logic pos;
        logic zero;
    } sign_flags_t;

    // entry selected by {c,b,a}, entry 0 at bit 0
    function automatic logic table_pick(input logic [7:0] tbl, input logic a,
                                        input logic b, input logic c);
        return tbl[{c, b, a}];
    endfunction

endpackage

// File: rtl/lut3_bitwise.sv
module lut3_bitwise #(
    parameter int WIDTH = 64
) (
    input  logic [7:0]       tbl,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic [WIDTH-1:0] in_c,
    output logic [WIDTH-1:0] out_y
);
    import lut3_pkg::*;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign out_y[i] = table_pick(tbl, in_a[i], in_b[i], in_c[i]);
    end

endmodule

// File: rtl/lut3_packed_lane.sv
module lut3_packed_lane #(
    parameter int XLEN      = 64,
    parameter int IDX_W     = 4,
    parameter int NARROW    = 8,
    parameter int WIDE      = 16
) (
    input  logic             wide_sel,
    input  logic [7:0]       tbl,
    input  logic [XLEN-1:0]  src,
    input  logic [XLEN-1:0]  old_dst,
    input  logic [IDX_W-1:0] idx_a,
    input  logic [IDX_W-1:0] idx_b,
    input  logic [IDX_W-1:0] idx_c,
    input  logic [IDX_W-1:0] idx_d,
    output logic [XLEN-1:0]  merged
);
    localparam int OFF_W = $clog2(XLEN + 1) + IDX_W + $clog2(WIDE) + 1;
    localparam logic [OFF_W-1:0] OFF_MAX = OFF_W'(XLEN);
    localparam logic [WIDE-1:0] MASK_N = WIDE'((1 << NARROW) - 1);
    localparam logic [WIDE-1:0] MASK_W = '1;

    logic [OFF_W-1:0] chunk;
    logic [WIDE-1:0]  lane_mask;
    logic [OFF_W-1:0] off_a, off_b, off_c, off_d;
    logic [WIDE-1:0]  lane_a, lane_b, lane_c, lane_y;
    logic [XLEN-1:0]  wr_mask, wr_data;

    function automatic logic [OFF_W-1:0] clamp_off(input logic [IDX_W-1:0] idx,
                                                   input logic [OFF_W-1:0] w);
        logic [OFF_W-1:0] raw;
        raw = OFF_W'(idx) * w;
        return (raw > OFF_MAX) ? OFF_MAX : raw;
    endfunction

    always_comb begin
        chunk     = wide_sel ? OFF_W'(WIDE) : OFF_W'(NARROW);
        lane_mask = wide_sel ? MASK_W : MASK_N;
        off_a     = clamp_off(idx_a, chunk);
        off_b     = clamp_off(idx_b, chunk);
        off_c     = clamp_off(idx_c, chunk);
        off_d     = clamp_off(idx_d, chunk);
        // shifting by the clamped offset fills with zeros past the top bit
        lane_a    = WIDE'(src >> off_a);
        lane_b    = WIDE'(src >> off_b);
        lane_c    = WIDE'(src >> off_c);
    end

    lut3_bitwise #(.WIDTH(WIDE)) u_lane_lut (
        .tbl   (tbl),
        .in_a  (lane_a),
        .in_b  (lane_b),
        .in_c  (lane_c),
        .out_y (lane_y)
    );

    always_comb begin
        wr_mask = XLEN'(lane_mask) << off_d;
        wr_data = XLEN'(lane_y & lane_mask) << off_d;
        merged  = (old_dst & ~wr_mask) | (wr_data & wr_mask);
    end

endmodule

// File: rtl/lut3_flag_gen.sv
module lut3_flag_gen #(
    parameter int XLEN = 64
) (
    input  logic                  enable,
    input  logic [XLEN-1:0]       value,
    output lut3_pkg::sign_flags_t fl
);
    logic is_zero;

    always_comb begin
        is_zero = (value == '0);
        fl.neg  = enable & value[XLEN-1];
        fl.zero = enable & is_zero;
        fl.pos  = enable & ~value[XLEN-1] & ~is_zero;
    end

endmodule

// File: rtl/lut3_unit.sv
module lut3_unit #(
    parameter int XLEN  = 64,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             mode_packed,
    input  logic             wide_chunk,
    input  logic             rec_en,
    input  logic [7:0]       table_imm,
    input  logic [XLEN-1:0]  op_a,
    input  logic [XLEN-1:0]  op_b,
    input  logic [XLEN-1:0]  op_d,
    input  logic [IDX_W-1:0] idx_a,
    input  logic [IDX_W-1:0] idx_b,
    input  logic [IDX_W-1:0] idx_c,
    input  logic [IDX_W-1:0] idx_d,
    output logic             out_valid,
    output logic [XLEN-1:0]  result,
    output logic [2:0]       flags
);
    import lut3_pkg::*;

    op_mode_e         mode;
    logic [XLEN-1:0]  full_y, packed_y, next_y;
    sign_flags_t      next_fl;

    assign mode = op_mode_e'(mode_packed);

    lut3_bitwise #(.WIDTH(XLEN)) u_full (
        .tbl   (table_imm),
        .in_a  (op_b),
        .in_b  (op_a),
        .in_c  (op_d),
        .out_y (full_y)
    );

    lut3_packed_lane #(.XLEN(XLEN), .IDX_W(IDX_W), .NARROW(8), .WIDE(16)) u_packed (
        .wide_sel (wide_chunk),
        .tbl      (op_b[7:0]),
        .src      (op_a),
        .old_dst  (op_d),
        .idx_a    (idx_a),
        .idx_b    (idx_b),
        .idx_c    (idx_c),
        .idx_d    (idx_d),
        .merged   (packed_y)
    );

    always_comb begin
        unique case (mode)
            OPM_FULL:   next_y = full_y;
            OPM_PACKED: next_y = packed_y;
            default:    next_y = full_y;
        endcase
    end

    lut3_flag_gen #(.XLEN(XLEN)) u_flags (
        .enable (rec_en),
        .value  (next_y),
        .fl     (next_fl)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            flags     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= next_y;
                flags  <= next_fl;
            end
        end
    end

endmodule

// File: rtl/lut3_unit_chk.sv
module lut3_unit_chk #(
    parameter int XLEN  = 64,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             mode_packed,
    input logic             wide_chunk,
    input logic             rec_en,
    input logic [7:0]       table_imm,
    input logic [XLEN-1:0]  op_a,
    input logic [XLEN-1:0]  op_b,
    input logic [XLEN-1:0]  op_d,
    input logic [IDX_W-1:0] idx_d,
    input logic             out_valid,
    input logic [XLEN-1:0]  result,
    input logic [2:0]       flags
);
    localparam int PW = IDX_W + 6;
    logic [PW-1:0] dst_off_raw;
    assign dst_off_raw = PW'(idx_d) * (wide_chunk ? PW'(16) : PW'(8));

    a_r2_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_valid_clr: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r3_sel_c: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode_packed && table_imm == 8'hF0) |=> result == $past(op_d));
    a_r3_sel_a: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode_packed && table_imm == 8'hAA) |=> result == $past(op_b));
    a_r7_keep_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_packed && !wide_chunk && idx_d == '0)
        |=> result[XLEN-1:8] == $past(op_d[XLEN-1:8]));
    a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_packed && dst_off_raw >= PW'(XLEN)) |=> result == $past(op_d));
    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rec_en) |=> $onehot(flags));
    a_r9_off: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !rec_en) |=> flags == 3'b000);
    a_r9_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flags[0] |-> result == '0);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(flags)));

endmodule

bind lut3_unit lut3_unit_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_packed(mode_packed),
    .wide_chunk(wide_chunk), .rec_en(rec_en), .table_imm(table_imm),
    .op_a(op_a), .op_b(op_b), .op_d(op_d), .idx_d(idx_d),
    .out_valid(out_valid), .result(result), .flags(flags)
);

// File: tb/tb_lut3_unit.sv
module tb_lut3_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, mode_packed = 1'b0, wide_chunk = 1'b0, rec_en = 1'b0;
    logic [7:0]  table_imm = '0;
    logic [63:0] op_a = '0, op_b = '0, op_d = '0;
    logic [3:0]  idx_a = '0, idx_b = '0, idx_c = '0, idx_d = '0;
    logic        out_valid;
    logic [63:0] result;
    logic [2:0]  flags;

    int checks = 0;
    int errors = 0;
    logic [63:0] seed = 64'h0123_4567_89AB_CDEF;

    lut3_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_packed(mode_packed),
        .wide_chunk(wide_chunk), .rec_en(rec_en), .table_imm(table_imm),
        .op_a(op_a), .op_b(op_b), .op_d(op_d),
        .idx_a(idx_a), .idx_b(idx_b), .idx_c(idx_c), .idx_d(idx_d),
        .out_valid(out_valid), .result(result), .flags(flags)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] rnd(inout logic [63:0] s);
        s = s ^ (s << 13);
        s = s ^ (s >> 7);
        s = s ^ (s << 17);
        return s;
    endfunction

    function automatic logic [63:0] ref_full(input logic [7:0] t, input logic [63:0] a,
                                             input logic [63:0] b, input logic [63:0] d);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) r[i] = t[4*d[i] + 2*a[i] + b[i]];
        return r;
    endfunction

    function automatic logic [63:0] ref_packed(input logic w16, input logic [63:0] a,
            input logic [7:0] t, input logic [63:0] d,
            input int ia, input int ib, input int ic, input int id);
        int wd, oa, ob, oc, od;
        logic xa, xb, xc;
        logic [63:0] r;
        wd = w16 ? 16 : 8;
        oa = (ia * wd > 64) ? 64 : ia * wd;
        ob = (ib * wd > 64) ? 64 : ib * wd;
        oc = (ic * wd > 64) ? 64 : ic * wd;
        od = (id * wd > 64) ? 64 : id * wd;
        r = d;
        for (int j = 0; j < wd; j++) begin
            xa = (oa + j < 64) ? a[oa + j] : 1'b0;
            xb = (ob + j < 64) ? a[ob + j] : 1'b0;
            xc = (oc + j < 64) ? a[oc + j] : 1'b0;
            if (od + j < 64) r[od + j] = t[4*xc + 2*xb + xa];
        end
        return r;
    endfunction

    function automatic logic [2:0] ref_flags(input logic en, input logic [63:0] v);
        if (!en) return 3'b000;
        if (v == 64'd0) return 3'b001;
        if (v[63]) return 3'b100;
        return 3'b010;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic pk, input logic w, input logic rc, input logic [7:0] t,
                         input logic [63:0] a, input logic [63:0] b, input logic [63:0] d,
                         input logic [3:0] ia, input logic [3:0] ib,
                         input logic [3:0] ic, input logic [3:0] id);
        @(negedge clk);
        in_valid = 1'b1; mode_packed = pk; wide_chunk = w; rec_en = rc; table_imm = t;
        op_a = a; op_b = b; op_d = d; idx_a = ia; idx_b = ib; idx_c = ic; idx_d = id;
        @(posedge clk);
        #1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 result", result, 64'd0);
        chk("R1 flags", 64'(flags), 64'd0);
    endtask

    task automatic t_full_random;
        logic [7:0] tabs [4] = '{8'h1E, 8'h6A, 8'hAA, 8'hF0};
        for (int k = 0; k < 4; k++) begin
            logic [63:0] a, b, d;
            a = rnd(seed); b = rnd(seed); d = rnd(seed);
            @(negedge clk);
            in_valid = 1'b1; mode_packed = 1'b0; rec_en = 1'b0; table_imm = tabs[k];
            op_a = a; op_b = b; op_d = d;
            @(posedge clk); #1;
            chk("R2 out_valid", 64'(out_valid), 64'd1);
            chk("R3 full lookup", result, ref_full(tabs[k], a, b, d));
            @(negedge clk); in_valid = 1'b0;
            @(posedge clk); #1;
            chk("R2 out_valid drop", 64'(out_valid), 64'd0);
        end
    endtask

    task automatic t_named_tables;
        logic [63:0] a, b, d;
        a = rnd(seed); b = rnd(seed); d = rnd(seed);
        issue(1'b0, 1'b0, 1'b0, 8'h96, a, b, d, 0, 0, 0, 0);
        chk("R4 xor3", result, a ^ b ^ d);
        issue(1'b0, 1'b0, 1'b0, 8'hE8, a, b, d, 0, 0, 0, 0);
        chk("R4 majority", result, (a & b) | (a & d) | (b & d));
        issue(1'b0, 1'b0, 1'b0, 8'hCA, a, b, d, 0, 0, 0, 0);
        chk("R4 select", result, (d & a) | (~d & b));
    endtask

    task automatic t_packed8;
        logic [63:0] a, d, b;
        a = rnd(seed); d = rnd(seed); b = {rnd(seed)} & 64'hFFFF_FFFF_FFFF_FF00 | 64'h96;
        issue(1'b1, 1'b0, 1'b0, 8'h00, a, b, d, 1, 6, 3, 2);
        chk("R5 R6 R7 packed 8-bit lane", result, ref_packed(1'b0, a, 8'h96, d, 1, 6, 3, 2));
        issue(1'b1, 1'b0, 1'b0, 8'hFF, a, b, d, 1, 6, 3, 2);
        chk("R6 table_imm ignored", result, ref_packed(1'b0, a, 8'h96, d, 1, 6, 3, 2));
        issue(1'b1, 1'b0, 1'b0, 8'h00, a, 64'hE8, d, 7, 0, 4, 0);
        chk("R7 lane 0 only", result, ref_packed(1'b0, a, 8'hE8, d, 7, 0, 4, 0));
    endtask

    task automatic t_packed16;
        logic [63:0] a, d;
        a = rnd(seed); d = rnd(seed);
        issue(1'b1, 1'b1, 1'b0, 8'h00, a, 64'hCA, d, 2, 0, 3, 1);
        chk("R5 packed 16-bit lane", result, ref_packed(1'b1, a, 8'hCA, d, 2, 0, 3, 1));
        issue(1'b1, 1'b1, 1'b0, 8'h00, a, 64'h1E, d, 1, 3, 0, 3);
        chk("R7 top 16-bit lane", result, ref_packed(1'b1, a, 8'h1E, d, 1, 3, 0, 3));
    endtask

    task automatic t_clamp;
        logic [63:0] d;
        d = rnd(seed);
        issue(1'b1, 1'b1, 1'b0, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h01, d, 15, 4, 9, 0);
        chk("R8 clamped sources read zero", result, {d[63:16], 16'hFFFF});
        issue(1'b1, 1'b0, 1'b0, 8'h00, rnd(seed), 64'hFF, d, 0, 1, 2, 12);
        chk("R8 clamped dest not written", result, d);
        issue(1'b1, 1'b0, 1'b0, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h80, d, 8, 7, 7, 7);
        chk("R8 offset 64 reads zero", result, {8'h00, d[55:0]});
    endtask

    task automatic t_flags;
        issue(1'b0, 1'b0, 1'b1, 8'hAA, 64'd0, 64'h8000_0000_0000_0001, 64'd0, 0, 0, 0, 0);
        chk("R9 negative", 64'(flags), 64'(ref_flags(1'b1, 64'h8000_0000_0000_0001)));
        issue(1'b0, 1'b0, 1'b1, 8'hAA, 64'd0, 64'h0000_0000_0000_0042, 64'd0, 0, 0, 0, 0);
        chk("R9 positive", 64'(flags), 64'd2);
        issue(1'b0, 1'b0, 1'b1, 8'h00, rnd(seed), rnd(seed), rnd(seed), 0, 0, 0, 0);
        chk("R9 zero", 64'(flags), 64'd1);
        issue(1'b0, 1'b0, 1'b0, 8'h00, rnd(seed), rnd(seed), rnd(seed), 0, 0, 0, 0);
        chk("R9 disabled", 64'(flags), 64'd0);
    endtask

    task automatic t_hold;
        logic [63:0] a, b, d, r0;
        logic [2:0] f0;
        a = rnd(seed); b = rnd(seed); d = rnd(seed);
        issue(1'b0, 1'b0, 1'b1, 8'h96, a, b, d, 0, 0, 0, 0);
        r0 = result; f0 = flags;
        chk("R10 captured", r0, a ^ b ^ d);
        op_a = rnd(seed); op_b = rnd(seed); op_d = rnd(seed); table_imm = 8'h00; rec_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 result held", result, r0);
        chk("R10 flags held", 64'(flags), 64'(f0));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_full_random();
        t_named_tables();
        t_packed8();
        t_packed16();
        t_clamp();
        t_flags();
        t_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule